// File: doc/BRIEF.md
# Split-Access 64-bit Tick Timer

A free-running 64-bit tick counter for a host whose bus is only 32 bits wide. An increment strobe, nominally pulsed once per millisecond, advances the count by one while the timer is running. At that rate the lower half wraps about every 49.7 days. The host sees the count as two 32-bit words. Reading the low word also copies the high word into a shadow register, and a later read of the high word returns that shadow copy. A low-then-high read pair therefore always describes one single instant, even when a carry into the upper half happens between the two accesses.

The timer has two sticky interrupt flags. The wrap flag rises on the same clock edge at which the low half rolls from all-ones to zero. The warning flag rises when a tick is applied while the low half equals a programmable threshold, which gives software advance notice of the coming rollover. Both flags are cleared by writing ones to a status word. While the timer is stopped, software can seed either half of the count.

Top module: `split_tick_timer`

## Requirements
- R1: A synchronous active-high reset clears the count, the shadow word, the threshold, the run bit, both flags and the read data register. After reset every register reads zero.
- R2: The count advances by exactly one on a clock edge only when the run bit (word 0, bit 0) is 1 and `tick_en` is high. The carry propagates from the low half into the high half. In all other cycles the count holds, unless a seed write changes it.
- R3: A read of word 1 returns the live low half and, on the same edge, copies the live high half into the shadow register. A read of word 2 returns the shadow register. Read data appears on `bus_rdata` in the cycle after the read strobe.
- R4: Writes to word 1 (low half) and word 2 (high half) load the count only while the run bit is 0. While the timer is running these writes are ignored.
- R5: The wrap flag (word 4, bit 0; output `irq_wrap`) becomes 1 on the same edge at which the low half steps from 0xFFFFFFFF to 0.
- R6: The warning flag (word 4, bit 1; output `irq_warn`) becomes 1 on the edge of a tick applied while the low half equals the threshold held in word 3.
- R7: Writing word 4 clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. A set and a clear of the same flag on one edge leave the flag at 1.
- R8: The output `irq` is 1 exactly when at least one of the two flags is 1.
- R9: Word 0 reads back the run bit in bit 0, and word 3 reads back the threshold. Words 5 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Increment strobe, one tick per high cycle |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (3) | Word address |
| bus_wdata | input | HALF_W (32) | Write data |
| bus_rdata | output | HALF_W (32) | Read data, registered |
| irq_wrap | output | 1 | Sticky low-half wrap flag |
| irq_warn | output | 1 | Sticky early-warning flag |
| irq | output | 1 | OR of both flags |

## Verification
Two pairs of functions can meet in one cycle. In the first, a low-word read lands on the very edge that carries into the high half. The bench drives the read strobe and a tick together while the low half is all-ones. It then expects the old low value and the old high value from the shadow, and expects the new pair on a repeated read. In the second, a write-one-to-clear of the wrap flag is driven in the same cycle as the tick that wraps the count, and the flag must stay set. Randomised runs with seeds placed near the wrap point also check the count and both flags against sums the bench computes itself.

// File: rtl/split_tick_timer.sv
module split_tick_timer #(
  parameter int HALF_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [HALF_W-1:0] bus_wdata,
  output logic [HALF_W-1:0] bus_rdata,
  output logic              irq_wrap,
  output logic              irq_warn,
  output logic              irq
);
  localparam int CNT_W = 2 * HALF_W;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_WARN = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(4);

  logic [CNT_W-1:0]  cnt;
  logic [HALF_W-1:0] shadow, warn_thr;
  logic              run, flg_wrap, flg_warn;
  logic [HALF_W-1:0] cnt_lo, cnt_hi;

  assign cnt_lo = cnt[HALF_W-1:0];
  assign cnt_hi = cnt[CNT_W-1:HALF_W];

  logic step, rd, wr_ctrl, wr_lo, wr_hi, wr_warn, wr_stat, wrap_hit, warn_hit;
  assign step     = run & tick_en;
  assign rd       = bus_sel & ~bus_wr;
  assign wr_ctrl  = bus_sel & bus_wr & (bus_addr == A_CTRL);
  assign wr_lo    = bus_sel & bus_wr & (bus_addr == A_LO);
  assign wr_hi    = bus_sel & bus_wr & (bus_addr == A_HI);
  assign wr_warn  = bus_sel & bus_wr & (bus_addr == A_WARN);
  assign wr_stat  = bus_sel & bus_wr & (bus_addr == A_STAT);
  assign wrap_hit = step & (&cnt_lo);
  assign warn_hit = step & (cnt_lo == warn_thr);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= cnt + CNT_W'(1);
    end else if (!run) begin
      if (wr_lo) cnt[HALF_W-1:0]     <= bus_wdata;
      if (wr_hi) cnt[CNT_W-1:HALF_W] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      warn_thr <= '0;
      flg_wrap <= 1'b0;
      flg_warn <= 1'b0;
    end else begin
      if (wr_ctrl) run      <= bus_wdata[0];
      if (wr_warn) warn_thr <= bus_wdata;
      flg_wrap <= (flg_wrap & ~(wr_stat & bus_wdata[0])) | wrap_hit;
      flg_warn <= (flg_warn & ~(wr_stat & bus_wdata[1])) | warn_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow    <= '0;
      bus_rdata <= '0;
    end else if (rd) begin
      if (bus_addr == A_LO) shadow <= cnt_hi;
      case (bus_addr)
        A_CTRL:  bus_rdata <= {{(HALF_W-1){1'b0}}, run};
        A_LO:    bus_rdata <= cnt_lo;
        A_HI:    bus_rdata <= shadow;
        A_WARN:  bus_rdata <= warn_thr;
        A_STAT:  bus_rdata <= {{(HALF_W-2){1'b0}}, flg_warn, flg_wrap};
        default: bus_rdata <= '0;
      endcase
    end
  end

  assign irq_wrap = flg_wrap;
  assign irq_warn = flg_warn;
  assign irq      = flg_wrap | flg_warn;
endmodule

// File: rtl/split_tick_timer_chk.sv
module split_tick_timer_chk #(
  parameter int HALF_W = 32,
  parameter int ADDR_W = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                tick_en,
  input logic                bus_sel,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [HALF_W-1:0]   bus_wdata,
  input logic [2*HALF_W-1:0] cnt,
  input logic [HALF_W-1:0]   shadow,
  input logic                run,
  input logic                irq_wrap,
  input logic                irq_warn,
  input logic [HALF_W-1:0]   warn_thr
);
  logic past_rst = 1'b0;
  always_ff @(posedge clk) past_rst <= rst;

  // R1
  always @(posedge clk) begin
    if (past_rst === 1'b1)
      reset_state_chk: assert (cnt == '0 && shadow == '0 && !run && !irq_wrap && !irq_warn);
  end

  // R2
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && tick_en) |=> (cnt == $past(cnt) + 1'b1));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!(run && tick_en) && !(bus_sel && bus_wr && (bus_addr == ADDR_W'(1) || bus_addr == ADDR_W'(2))))
    |=> $stable(cnt));

  // R4
  seed_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !tick_en) |=> $stable(cnt));

  // R3
  shadow_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && bus_addr == ADDR_W'(1)) |=> (shadow == $past(cnt[2*HALF_W-1:HALF_W])));

  // R5
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (run && tick_en && (&cnt[HALF_W-1:0])) |=> (irq_wrap && cnt[HALF_W-1:0] == '0));

  // R6
  warn_chk: assert property (@(posedge clk) disable iff (rst)
    (run && tick_en && cnt[HALF_W-1:0] == warn_thr) |=> irq_warn);

  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_wrap && !(bus_sel && bus_wr && bus_addr == ADDR_W'(4) && bus_wdata[0])) |=> irq_wrap);
endmodule

bind split_tick_timer split_tick_timer_chk #(.HALF_W(HALF_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt(cnt), .shadow(shadow), .run(run),
  .irq_wrap(irq_wrap), .irq_warn(irq_warn), .warn_thr(warn_thr)
);

// File: tb/sim_split_tick_timer.sv
module sim_split_tick_timer;
  localparam int CLK_P = 10;
  localparam logic [2:0] W_CTRL = 3'd0, W_LO = 3'd1, W_HI = 3'd2, W_WARN = 3'd3, W_STAT = 3'd4;

  logic clk = 1'b0, rst = 1'b1, tick_en = 1'b0, bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq_wrap, irq_warn, irq;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  split_tick_timer u0 (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_wrap(irq_wrap), .irq_warn(irq_warn), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic ticks(input int cyc, input bit rnd, output int n);
    n = 0;
    for (int i = 0; i < cyc; i++) begin
      tick_en = rnd ? 1'($urandom % 2) : 1'b1;
      if (tick_en) n++;
      @(negedge clk);
    end
    tick_en = 0;
  endtask

  function automatic logic [63:0] exp_count(input logic [63:0] s, input int n);
    return s + 64'(n);
  endfunction
  function automatic bit exp_wrap(input logic [31:0] s, input int n);
    return ({1'b0, s} + 33'(n)) > 33'h0_FFFF_FFFF;
  endfunction
  function automatic bit exp_warn(input logic [31:0] s, input logic [31:0] t, input int n);
    logic [31:0] d = t - s;
    return d < 32'(n);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d, lo, hi, thr;
    int n;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    rd(W_CTRL, d); chk("R1 ctrl", d, 0);
    rd(W_LO, d);   chk("R1 low", d, 0);
    rd(W_HI, d);   chk("R1 high", d, 0);
    rd(W_STAT, d); chk("R1 status", d, 0);
    rd(W_WARN, d); chk("R1 threshold", d, 0);
    chk("R1 irq", {irq, irq_wrap, irq_warn}, 0);

    // R2 advance only on strobe while running
    wr(W_LO, 32'd10); wr(W_HI, 32'd0);
    ticks(4, 0, n);
    rd(W_LO, d); chk("R2 stopped holds", d, 10);
    wr(W_CTRL, 1);
    rd(W_CTRL, d); chk("R9 ctrl readback", d, 1);
    for (int i = 0; i < 6; i++) begin tick_en = (i % 2 == 0); @(negedge clk); end
    tick_en = 0;
    wr(W_CTRL, 0);
    rd(W_LO, d); chk("R2 three ticks", d, 13);

    // R2 carry, R5 same-edge wrap flag
    wr(W_STAT, 3);
    wr(W_LO, 32'hFFFF_FFFE); wr(W_HI, 32'h1234_5678); wr(W_CTRL, 1);
    tick_en = 1; @(negedge clk); tick_en = 0;
    chk("R5 no wrap before", irq_wrap, 0);
    tick_en = 1; @(negedge clk); tick_en = 0;
    chk("R5 wrap same edge", irq_wrap, 1);
    chk("R8 irq on wrap", irq, 1);
    wr(W_CTRL, 0);
    rd(W_LO, d); chk("R2 carry low", d, 0);
    rd(W_HI, d); chk("R2 carry high", d, 32'h1234_5679);

    // R7 clear, zero-bit no effect
    wr(W_STAT, 2); chk("R7 zero bit keeps", irq_wrap, 1);
    wr(W_STAT, 1); chk("R7 w1c clears", irq_wrap, 0);
    chk("R8 irq idle", irq, 0);

    // R3 read on the carry edge
    wr(W_LO, 32'hFFFF_FFFF); wr(W_HI, 32'd7); wr(W_CTRL, 1);
    bus_sel = 1; bus_wr = 0; bus_addr = W_LO; tick_en = 1;
    @(negedge clk);
    bus_sel = 0; tick_en = 0; d = bus_rdata;
    chk("R3 low before carry", d, 32'hFFFF_FFFF);
    rd(W_HI, d); chk("R3 shadow keeps old high", d, 7);
    rd(W_LO, d); chk("R3 low after carry", d, 0);
    rd(W_HI, d); chk("R3 high after carry", d, 8);

    // R4 seed ignored while running
    wr(W_LO, 32'hAAAA); wr(W_HI, 32'hBBBB);
    rd(W_LO, d); chk("R4 low ignored", d, 0);
    rd(W_HI, d); chk("R4 high ignored", d, 8);
    wr(W_CTRL, 0);
    wr(W_LO, 32'h55);
    rd(W_LO, d); chk("R4 seed when stopped", d, 32'h55);

    // R6 warning
    wr(W_STAT, 3);
    wr(W_WARN, 32'h100);
    rd(W_WARN, d); chk("R9 threshold readback", d, 32'h100);
    wr(W_LO, 32'hFE); wr(W_CTRL, 1);
    tick_en = 1; @(negedge clk); chk("R6 not yet FE", irq_warn, 0);
    @(negedge clk); chk("R6 not yet FF", irq_warn, 0);
    @(negedge clk); tick_en = 0; chk("R6 fires at threshold", irq_warn, 1);
    chk("R8 irq on warn", irq, 1);
    wr(W_CTRL, 0);
    rd(W_STAT, d); chk("R6 status bit1", d, 2);

    // R7 set and clear in one cycle
    wr(W_STAT, 3);
    wr(W_LO, 32'hFFFF_FFFF); wr(W_CTRL, 1);
    bus_sel = 1; bus_wr = 1; bus_addr = W_STAT; bus_wdata = 1; tick_en = 1;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; tick_en = 0;
    chk("R7 set beats clear", irq_wrap, 1);
    wr(W_CTRL, 0);

    // R9 unused words
    for (int a = 5; a < 8; a++) begin rd(3'(a), d); chk("R9 unused word", d, 0); end

    // Random runs: R2 R5 R6
    for (int it = 0; it < 40; it++) begin
      lo  = (it % 2 == 0) ? (32'hFFFF_FFFF - ($urandom % 40)) : $urandom;
      hi  = $urandom;
      thr = lo + ($urandom % 60);
      wr(W_CTRL, 0); wr(W_STAT, 3);
      wr(W_LO, lo); wr(W_HI, hi); wr(W_WARN, thr); wr(W_CTRL, 1);
      ticks(20 + int'($urandom % 40), 1, n);
      wr(W_CTRL, 0);
      rd(W_LO, d); chk("R2 random low", d, exp_count({hi, lo}, n) & 64'hFFFF_FFFF);
      rd(W_HI, d); chk("R2 random high", d, exp_count({hi, lo}, n) >> 32);
      rd(W_STAT, d);
      chk("R5 R6 random flags", d, {30'd0, exp_warn(lo, thr, n), exp_wrap(lo, n)});
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule